// File: doc/BRIEF.md
# Conversion Cycle Sequencer with Sync

This block paces the conversion periods of an oversampling converter's digital back end. A modulator-count counter runs from zero up to a terminal value. Each clock it adds one modulator sample (`mod_in`) into a partial sum. When the counter reaches its terminal value, the partial sum for that period is captured. A short state machine then raises a busy flag, commits a new result into the output data register, and lowers the flag again.

The result is a stand-in for the filter arithmetic. It is the sum of the newest partial and the `HIST_N` partials before it, and those older partials are held in a small history record. A synchronisation request, from the `sync_pin` input or the `sync_cmd` command strobe, restarts the modulator count. It also throws away the samples gathered so far in the current period. It never clears the history record, so the period in which it arrives is longer than usual.

A remaining-outputs counter tracks how many committed results are still needed after a channel change before the output is trustworthy. `data_ok` reports when that counter is empty. A sync after a channel change shortens the wait by one output, because the period then in progress contains only samples from the new channel.

The sequencing state machine has three states:
- `S_COUNT`: the counter runs.
- `S_HOLD`: the period has ended, and the flag is high before the write.
- `S_COMMIT`: the register has just been written, and the flag is still high.

Its transitions are:
- `S_COUNT` goes to `S_HOLD` on a natural end of count with no sync.
- `S_HOLD` goes to `S_COMMIT` unconditionally, and this is the transition that writes the register.
- `S_COMMIT` goes back to `S_COUNT` unconditionally.

Top module: `conv_cycle_seq`

## Requirements
- R1: Without sync, the modulator count runs 0 to `CNT_TERM` and wraps to 0. A conversion period is therefore exactly `CNT_TERM+1` clocks.
- R2: `upd_busy` rises at the clock edge that ends a period and stays high for exactly two clocks. `data_out` is rewritten at the second of those edges, while `upd_busy` is still high. `upd_busy` falls at the third edge.
- R3: A partial is the sum of `mod_in` over every clock of a period, counted from the clock after a restart up to and including the end clock. The new `data_out` is that partial plus the two previous partials. Each new result overwrites the previous one, whether or not it was read.
- R4: A sync request on `sync_pin` or `sync_cmd` resets the count to 0 and discards the samples of the current period, including the one on that clock. The two stored partials are kept, so after a sync the next period end comes `CNT_TERM+1` clocks later. A request held high holds the count at 0 and produces no results.
- R5: A sync on the same clock as the natural end of count produces no result. `upd_busy` stays low, and a full new period starts.
- R6: During reset, `data_out` is 0, `upd_busy` is 0, the history is 0, `data_ok` is 0, and 4 results are outstanding.
- R7: `chan_change` sets the outstanding count to 4, and `data_ok` is low from the next clock. Each commit lowers the count by one. `data_ok` is high when it reaches 0, which is after 4 period ends.
- R8: A sync sets the outstanding count to 3 if it is above 3, and leaves it unchanged otherwise. In particular it leaves `data_ok` high when the count is 0. `chan_change` and a sync on the same clock give 3.
- R9: `chan_change` on the same clock as a commit wins, and the count becomes 4 without the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_in | input | IN_W | Modulator sample added each clock |
| sync_pin | input | 1 | Synchronisation request from the pin |
| sync_cmd | input | 1 | Synchronisation request from the command bit |
| chan_change | input | 1 | Pulse marking an input channel change |
| data_out | output | RES_W | Output data register |
| upd_busy | output | 1 | High around each output register update |
| data_ok | output | 1 | Output data fully from the current channel |

## Verification
The assertions take several things for granted:
- `CNT_TERM` is at least 3, so a new period end can never fall inside `S_HOLD` or `S_COMMIT`.
- `sync_pin`, `sync_cmd` and `chan_change` are synchronous to `clk` and are sampled as plain per-clock levels.

The stimulus changes every input only on the falling edge and uses the default parameters. It times syncs and channel changes from its own count of the period. This lets it hit the end clock and the commit clock on purpose, without ever breaking those conditions.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        S_COUNT  = 2'd0,
        S_HOLD   = 2'd1,
        S_COMMIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cs_mod_counter.sv
module cs_mod_counter #(
    parameter int CNT_TERM = 15,
    parameter int IN_W     = 4,
    parameter int CNT_W    = 4,
    parameter int PART_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    input  logic [IN_W-1:0]   mod_in,
    output logic              end_evt,
    output logic [PART_W-1:0] part_q
);

    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(CNT_TERM);

    logic [CNT_W-1:0]  cnt_q;
    logic [PART_W-1:0] acc_q;
    logic [PART_W-1:0] sample_ext;
    logic              at_term;

    assign sample_ext = PART_W'(mod_in);
    assign at_term    = (cnt_q == TERM_V);
    assign end_evt    = at_term && !sync_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            part_q <= '0;
        end else if (sync_req) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (at_term) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            part_q <= acc_q + sample_ext;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            acc_q <= acc_q + sample_ext;
        end
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (cnt_q == '0) && (acc_q == '0)); // R4

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/cs_filter_hist.sv
module cs_filter_hist #(
    parameter int PART_W = 8,
    parameter int HIST_N = 2,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [PART_W-1:0] part_q,
    output logic [RES_W-1:0]  data_q
);

    logic [PART_W-1:0] hist_q [HIST_N];
    logic [RES_W-1:0]  sum_chain [HIST_N+1];

    assign sum_chain[0] = RES_W'(part_q);

    for (genvar g = 0; g < HIST_N; g++) begin : g_hist
        assign sum_chain[g+1] = sum_chain[g] + RES_W'(hist_q[g]);

        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist_q[g] <= '0;
                else if (commit)
                    hist_q[g] <= part_q;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist_q[g] <= '0;
                else if (commit)
                    hist_q[g] <= hist_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (commit)
            data_q <= sum_chain[HIST_N];
    end

endmodule

// File: rtl/cs_valid_track.sv
module cs_valid_track #(
    parameter int HIST_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic sync_req,
    input  logic chan_change,
    output logic data_ok
);

    localparam int REM_INIT = HIST_N + 2;
    localparam int REM_SYNC = HIST_N + 1;
    localparam int REM_W    = $clog2(REM_INIT + 1);
    localparam logic [REM_W-1:0] REM_INIT_V = REM_W'(REM_INIT);
    localparam logic [REM_W-1:0] REM_SYNC_V = REM_W'(REM_SYNC);

    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] rem_dec;
    logic [REM_W-1:0] rem_nxt;

    always_comb begin
        rem_dec = rem_q;
        if (commit && (rem_q != '0))
            rem_dec = rem_q - 1'b1;
        if (chan_change)
            rem_nxt = sync_req ? REM_SYNC_V : REM_INIT_V;
        else if (sync_req && (rem_dec > REM_SYNC_V))
            rem_nxt = REM_SYNC_V;
        else
            rem_nxt = rem_dec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= REM_INIT_V;
        else
            rem_q <= rem_nxt;
    end

    assign data_ok = (rem_q == '0);

    AST_CHG_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        chan_change |=> !data_ok); // R7

    AST_SYNC_CAPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !chan_change) |=> (rem_q <= REM_SYNC_V)); // R8

    AST_CHG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_change && !sync_req) |=> (rem_q == REM_INIT_V)); // R9

endmodule

// File: rtl/conv_cycle_seq.sv
module conv_cycle_seq
    import conv_seq_pkg::*;
#(
    parameter int CNT_TERM = 15,
    parameter int IN_W     = 4,
    parameter int HIST_N   = 2,
    localparam int CNT_W   = $clog2(CNT_TERM + 1),
    localparam int PART_W  = IN_W + CNT_W,
    localparam int RES_W   = PART_W + $clog2(HIST_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  mod_in,
    input  logic             sync_pin,
    input  logic             sync_cmd,
    input  logic             chan_change,
    output logic [RES_W-1:0] data_out,
    output logic             upd_busy,
    output logic             data_ok
);

    seq_state_e        state_q;
    seq_state_e        state_nxt;
    logic              sync_any;
    logic              end_evt;
    logic              commit;
    logic [PART_W-1:0] part_q;

    assign sync_any = sync_pin | sync_cmd;

    cs_mod_counter #(
        .CNT_TERM (CNT_TERM),
        .IN_W     (IN_W),
        .CNT_W    (CNT_W),
        .PART_W   (PART_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_any),
        .mod_in   (mod_in),
        .end_evt  (end_evt),
        .part_q   (part_q)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            S_COUNT:  if (end_evt) state_nxt = S_HOLD;
            S_HOLD:   state_nxt = S_COMMIT;
            S_COMMIT: state_nxt = S_COUNT;
            default:  state_nxt = S_COUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_COUNT;
        else
            state_q <= state_nxt;
    end

    // Outputs of the sequencer
    always_comb begin
        upd_busy = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            S_COUNT:  upd_busy = 1'b0;
            S_HOLD: begin
                upd_busy = 1'b1;
                commit   = 1'b1;
            end
            S_COMMIT: upd_busy = 1'b1;
            default:  upd_busy = 1'b0;
        endcase
    end

    cs_filter_hist #(
        .PART_W (PART_W),
        .HIST_N (HIST_N),
        .RES_W  (RES_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .part_q (part_q),
        .data_q (data_out)
    );

    cs_valid_track #(
        .HIST_N (HIST_N)
    ) u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .sync_req    (sync_any),
        .chan_change (chan_change),
        .data_ok     (data_ok)
    );

    AST_DATA_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> upd_busy); // R2

    AST_HOLD_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> (state_q == S_COMMIT)); // R2

    AST_SYNC_AT_END_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_any && state_q == S_COUNT) |=> (state_q == S_COUNT)); // R5

endmodule

// File: tb/conv_cycle_seq_test.sv
module conv_cycle_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TERM  = 15;
    localparam int IN_W  = 4;
    localparam int RES_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [IN_W-1:0]  mod_in;
    logic             sync_pin, sync_cmd, chan_change;
    logic [RES_W-1:0] data_out;
    logic             upd_busy, data_ok;

    int nchecks = 0;
    int nerr    = 0;
    int rises   = 0;
    bit done    = 0;
    int exp_q[$];

    // bench-side model state
    int m_cnt = 0, m_acc = 0, m_part = 0, m_h0 = 0, m_h1 = 0;
    int m_phase = 0, m_rem = 4;

    conv_cycle_seq #(.CNT_TERM(TERM), .IN_W(IN_W), .HIST_N(2)) uut (
        .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .sync_pin(sync_pin),
        .sync_cmd(sync_cmd), .chan_change(chan_change), .data_out(data_out),
        .upd_busy(upd_busy), .data_ok(data_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        nchecks++;
        if (!good) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected result each time the busy flag falls
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!prev_busy && upd_busy) rises++;
            if (prev_busy && !upd_busy) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R3 unexpected result", int'(data_out), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(data_out) == e, "R3 result", int'(data_out), e);
                end
            end
            prev_busy = upd_busy;
        end
    end

    // Driver: one clock edge; updates the model and pushes expected results
    task automatic step(input int m, input bit sp, input bit sc, input bit chg);
        bit s, com;
        int nr;
        mod_in = IN_W'(m); sync_pin = sp; sync_cmd = sc; chan_change = chg;
        s = sp | sc;
        com = (m_phase == 1);
        nr = m_rem;
        if (chg) nr = s ? 3 : 4;
        else begin
            if (com && nr != 0) nr--;
            if (s && nr > 3) nr = 3;
        end
        m_rem = nr;
        if (com) begin
            exp_q.push_back(m_part + m_h0 + m_h1);
            m_h1 = m_h0;
            m_h0 = m_part;
        end
        if (m_phase == 1) m_phase = 2;
        else if (m_phase == 2) m_phase = 0;
        else if (!s && m_cnt == TERM) m_phase = 1;
        if (s) begin m_cnt = 0; m_acc = 0; end
        else if (m_cnt == TERM) begin m_part = m_acc + m; m_cnt = 0; m_acc = 0; end
        else begin m_cnt++; m_acc += m; end
        @(negedge clk);
        chk(upd_busy == (m_phase != 0), "R1 R2 busy timing", int'(upd_busy), int'(m_phase != 0));
        chk(data_ok == (m_rem == 0), "R7 data_ok", int'(data_ok), int'(m_rem == 0));
    endtask

    task automatic run(input int n, input int modv);
        for (int i = 0; i < n; i++) step((modv < 0) ? (i % 7) : modv, 0, 0, 0);
    endtask

    task automatic to_end();
        for (int i = 0; i < 100 && m_cnt != TERM; i++) step(2, 0, 0, 0);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        for (int i = 0; i < 100 && !upd_busy; i++) begin step(1, 0, 0, 0); n++; end
    endtask

    task automatic wait_ok(output int r);
        int r0;
        r0 = rises;
        for (int i = 0; i < 300 && !data_ok; i++) step(3, 0, 0, 0);
        r = rises - r0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        int n, r;
        rst_n = 1'b0; mod_in = '0; sync_pin = 0; sync_cmd = 0; chan_change = 0;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(data_out == '0, "R6 data_out in reset", int'(data_out), 0);
        chk(upd_busy == 1'b0, "R6 busy in reset", int'(upd_busy), 0);
        chk(data_ok == 1'b0, "R6 data_ok in reset", int'(data_ok), 0);
        rst_n = 1'b1;

        // R1 R3 constant input, then varying input
        run(70, 1);
        chk(data_ok == 1'b1, "R7 ok after 4 results from reset", int'(data_ok), 1);
        run(70, -1);

        // R4 sync from pin mid-period
        to_end(); run(5, 0);
        step(9, 1, 0, 0);
        wait_busy(n);
        chk(n == TERM + 1, "R4 pin sync stretches period", n, TERM + 1);
        run(20, 5);

        // R4 sync from command bit
        to_end(); run(8, 0);
        step(9, 0, 1, 0);
        wait_busy(n);
        chk(n == TERM + 1, "R4 cmd sync stretches period", n, TERM + 1);
        run(20, 4);

        // R5 sync on the end clock
        to_end();
        step(7, 1, 0, 0);
        chk(upd_busy == 1'b0, "R5 no result on end-clock sync", int'(upd_busy), 0);
        wait_busy(n);
        chk(n == TERM + 1, "R5 full new period after end-clock sync", n, TERM + 1);
        run(20, 6);

        // R4 held sync produces nothing
        r = rises;
        for (int i = 0; i < 40; i++) step(15, 1, 0, 0);
        chk(rises == r, "R4 held sync gives no result", rises - r, 0);
        run(40, 2);

        // R7 channel change without sync
        to_end(); run(5, 1);
        step(1, 0, 0, 1);
        chk(data_ok == 1'b0, "R7 ok drops on change", int'(data_ok), 1'b0);
        wait_ok(r);
        chk(r == 4, "R7 four results after change", r, 4);

        // R8 change then sync later in same period
        to_end(); run(3, 1);
        step(2, 0, 0, 1);
        run(4, 2);
        step(3, 1, 0, 0);
        wait_ok(r);
        chk(r == 3, "R8 sync shortens wait", r, 3);

        // R8 change and sync on the same clock
        to_end(); run(4, 1);
        step(2, 0, 1, 1);
        wait_ok(r);
        chk(r == 3, "R8 change with sync same clock", r, 3);

        // R8 sync while data valid leaves it valid
        run(5, 1);
        step(1, 1, 0, 0);
        chk(data_ok == 1'b1, "R8 sync keeps valid", int'(data_ok), 1);

        // R9 change on the commit clock
        to_end();
        step(4, 0, 0, 0);
        step(4, 0, 0, 1);
        wait_ok(r);
        chk(r == 4, "R9 change beats commit decrement", r, 4);

        run(60, -1);
        chk(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule